// File: doc/BRIEF.md
# TDM Highway Serial Port

This block is the bit-level port of a serial time-division-multiplex highway. It sits in the system clock domain and oversamples four external signals: a data clock, a frame sync, a receive data line and (on its output side) a transmit data line with an output enable. It locates the start of every frame from the frame sync and counts bit cells from there. It shifts one byte per 8-bit time slot out on the transmit line and gathers one byte per slot from the receive line. The user logic sees a bit count, a slot index, a byte-request strobe on transmit and a byte-valid strobe on receive.

The frame length is never configured. Each frame sync restarts the count, and the count runs until the next one. The data clock can run at twice the bit rate or at the bit rate. At twice the rate the receive sampling point is selectable between one quarter and three quarters of the bit cell. A standalone input forces the double-rate clock. Each slot can be driven open-drain or push-pull, and a slot the user does not claim is left released so that it reads as ones.

Top module: `tdm_highway_port`

## Requirements
- R1: From reset until the first frame sync rising edge has been seen at a data clock rising edge, `txd_o` is 1, `tx_oe_o` is 0, `bit_cnt_o` is 0 and `rx_valid_o` never pulses, whatever the data clock does.
- R2: A frame sync rising edge starts a frame at the same or next data clock rising edge. That cell has bit count 0, and each further bit cell adds one. The slot index is the bit count divided by 8.
- R3: Transmit data is sent most significant bit first. A new bit appears at the start of each bit cell (a data clock rising edge). At every cell whose bit count is a multiple of 8, `tx_byte_i` and `tx_slot_en_i` are taken and `tx_take_o` pulses for one cycle with that slot on `tx_slot_o`.
- R4: With `single_rate_i`=1 a bit cell is one data clock period. With `single_rate_i`=0 it is two periods, and the transmit bit holds through both.
- R5: With `standalone_i`=1 the port uses two-period bit cells even when `single_rate_i`=1.
- R6: In two-period cells the receive bit is sampled on the first falling data clock edge of the cell when `early_sample_i`=1, and on the second falling edge when it is 0. In one-period cells it is sampled on the single falling edge, and `early_sample_i` has no effect.
- R7: When the eighth bit of a slot is sampled, `rx_valid_o` pulses for one cycle. `rx_byte_o` then holds the slot with its first received bit in bit 7, and `rx_slot_o` holds the slot index. A slot cut short by the next frame sync is never reported.
- R8: In an enabled slot, `txd_o` shows the bit. With `open_drain_i`=1, `tx_oe_o` is 1 only while the bit is 0; with `open_drain_i`=0 it is 1 for every bit. In a disabled slot, `txd_o` is 1 and `tx_oe_o` is 0.
- R9: The bit count saturates at 2^CNT_W-1 and falls back only to 0, at a frame start. From the saturated cell on, the transmit line is released and no receive slot is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the data clock |
| rst_n | input | 1 | Active-low reset |
| dclk_i | input | 1 | Highway data clock |
| fsync_i | input | 1 | Frame sync, rising edge marks a frame start |
| rxd_i | input | 1 | Receive data line |
| single_rate_i | input | 1 | 1: data clock equals bit rate |
| standalone_i | input | 1 | 1: force double-rate clocking |
| early_sample_i | input | 1 | 1: sample at first falling edge of a double-rate cell |
| open_drain_i | input | 1 | 1: enable output only for zero bits |
| tx_byte_i | input | 8 | Byte for the slot being loaded |
| tx_slot_en_i | input | 1 | The slot being loaded is driven |
| txd_o | output | 1 | Transmit data |
| tx_oe_o | output | 1 | Transmit output enable |
| tx_take_o | output | 1 | Transmit byte taken strobe |
| tx_slot_o | output | CNT_W-3 | Slot index of the taken byte |
| bit_cnt_o | output | CNT_W | Bit cell count in the frame |
| rx_byte_o | output | 8 | Received slot byte |
| rx_valid_o | output | 1 | Received byte strobe |
| rx_slot_o | output | CNT_W-3 | Slot index of the received byte |

## Verification
A frame start and the end of a byte often fall together. A new frame sync can arrive while a slot is half shifted, so the shift registers must reload and drop the partial slot. The saturating count can also run into the slot boundary at the cell where it stops. Back-to-back frames of random lengths, including lengths that are not multiples of 8 and one frame longer than the count range, provoke both cases. The bench judges them by the number and content of the reported receive slots, and by whether the transmit line is released or driven at each cell.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
    localparam int unsigned SLOT_BITS = 8;
    localparam int unsigned SLOT_SHIFT = 3;
    typedef logic [SLOT_BITS-1:0] slot_byte_t;
endpackage

// File: rtl/tdm_edge_sync.sv
module tdm_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dclk_i,
    input  logic fsync_i,
    input  logic rxd_i,
    output logic dclk_rise_o,
    output logic dclk_fall_o,
    output logic fs_rise_o,
    output logic rxd_o
);
    typedef struct packed {
        logic [STAGES-1:0] dclk_sr;
        logic [STAGES-1:0] fs_sr;
        logic [STAGES-1:0] rxd_sr;
        logic              dclk_prev;
        logic              fs_prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d           = sync_q;
        sync_d.dclk_sr   = {sync_q.dclk_sr[STAGES-2:0], dclk_i};
        sync_d.fs_sr     = {sync_q.fs_sr[STAGES-2:0], fsync_i};
        sync_d.rxd_sr    = {sync_q.rxd_sr[STAGES-2:0], rxd_i};
        sync_d.dclk_prev = sync_q.dclk_sr[STAGES-1];
        sync_d.fs_prev   = sync_q.fs_sr[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q.dclk_sr   <= '0;
            sync_q.fs_sr     <= '0;
            sync_q.rxd_sr    <= '1;
            sync_q.dclk_prev <= 1'b0;
            sync_q.fs_prev   <= 1'b0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign dclk_rise_o = sync_q.dclk_sr[STAGES-1] & ~sync_q.dclk_prev;
    assign dclk_fall_o = ~sync_q.dclk_sr[STAGES-1] & sync_q.dclk_prev;
    assign fs_rise_o   = sync_q.fs_sr[STAGES-1] & ~sync_q.fs_prev;
    assign rxd_o       = sync_q.rxd_sr[STAGES-1];
endmodule

// File: rtl/tdm_bit_timer.sv
module tdm_bit_timer #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dclk_rise_i,
    input  logic             dclk_fall_i,
    input  logic             fs_rise_i,
    input  logic             double_rate_i,
    input  logic             early_i,
    output logic             cell_start_o,
    output logic             frame_start_o,
    output logic             rx_sample_o,
    output logic             framed_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_next_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             pend;
        logic             half;
        logic             framed;
        logic [CNT_W-1:0] cnt;
    } timer_t;

    timer_t tm_d, tm_q;
    logic   start;

    always_comb begin
        tm_d          = tm_q;
        cell_start_o  = 1'b0;
        rx_sample_o   = 1'b0;
        start         = dclk_rise_i & (fs_rise_i | tm_q.pend);
        tm_d.pend     = (tm_q.pend | fs_rise_i) & ~dclk_rise_i;
        if (start) begin
            tm_d.half    = 1'b0;
            tm_d.cnt     = '0;
            tm_d.framed  = 1'b1;
            cell_start_o = 1'b1;
        end else if (dclk_rise_i && tm_q.framed) begin
            tm_d.half = double_rate_i ? ~tm_q.half : 1'b0;
            if (!tm_d.half) begin
                cell_start_o = 1'b1;
                if (tm_q.cnt != CNT_MAX) tm_d.cnt = tm_q.cnt + 1'b1;
            end
        end
        if (dclk_fall_i && tm_q.framed) begin
            rx_sample_o = !double_rate_i || (early_i ? !tm_q.half : tm_q.half);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign frame_start_o = start;
    assign framed_o      = tm_q.framed;
    assign cnt_o         = tm_q.cnt;
    assign cnt_next_o    = tm_d.cnt;

    // R6
    edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cell_start_o, rx_sample_o}));

    // R2
    framed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        framed_o |=> framed_o);
endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser #(
    parameter int unsigned CNT_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start_i,
    input  logic                sample_i,
    input  logic                rxd_i,
    output tdm_pkg::slot_byte_t rx_byte_o,
    output logic                rx_valid_o,
    output logic [CNT_W-4:0]    rx_slot_o
);
    import tdm_pkg::*;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] pos;
        slot_byte_t       sh;
        slot_byte_t       byte_v;
        logic             valid;
        logic [CNT_W-4:0] slot;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d       = rx_q;
        rx_d.valid = 1'b0;
        if (frame_start_i) begin
            rx_d.pos = '0;
        end else if (sample_i && rx_q.pos != CNT_MAX) begin
            rx_d.sh  = {rx_q.sh[SLOT_BITS-2:0], rxd_i};
            rx_d.pos = rx_q.pos + 1'b1;
            if (rx_q.pos[SLOT_SHIFT-1:0] == 3'd7) begin
                rx_d.valid  = 1'b1;
                rx_d.byte_v = {rx_q.sh[SLOT_BITS-2:0], rxd_i};
                rx_d.slot   = rx_q.pos[CNT_W-1:SLOT_SHIFT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign rx_byte_o  = rx_q.byte_v;
    assign rx_valid_o = rx_q.valid;
    assign rx_slot_o  = rx_q.slot;

    // R7
    rx_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);
endmodule

// File: rtl/tdm_tx_ser.sv
module tdm_tx_ser #(
    parameter int unsigned CNT_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cell_start_i,
    input  logic [CNT_W-1:0]    cnt_next_i,
    input  tdm_pkg::slot_byte_t tx_byte_i,
    input  logic                tx_en_i,
    input  logic                od_i,
    output logic                txd_o,
    output logic                tx_oe_o,
    output logic                tx_take_o,
    output logic [CNT_W-4:0]    tx_slot_o
);
    import tdm_pkg::*;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        slot_byte_t       sh;
        logic             en;
        logic             take;
        logic [CNT_W-4:0] slot;
    } tx_t;

    tx_t tx_d, tx_q;

    always_comb begin
        tx_d      = tx_q;
        tx_d.take = 1'b0;
        if (cell_start_i) begin
            if (cnt_next_i == CNT_MAX) begin
                tx_d.en = 1'b0;
            end else if (cnt_next_i[SLOT_SHIFT-1:0] == '0) begin
                tx_d.sh   = tx_byte_i;
                tx_d.en   = tx_en_i;
                tx_d.take = 1'b1;
                tx_d.slot = cnt_next_i[CNT_W-1:SLOT_SHIFT];
            end else begin
                tx_d.sh = {tx_q.sh[SLOT_BITS-2:0], 1'b1};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q.sh   <= '1;
            tx_q.en   <= 1'b0;
            tx_q.take <= 1'b0;
            tx_q.slot <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign txd_o     = tx_q.en ? tx_q.sh[SLOT_BITS-1] : 1'b1;
    assign tx_oe_o   = tx_q.en & (od_i ? ~tx_q.sh[SLOT_BITS-1] : 1'b1);
    assign tx_take_o = tx_q.take;
    assign tx_slot_o = tx_q.slot;

    // R8
    od_zero_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (od_i && tx_oe_o) |-> !txd_o);
endmodule

// File: rtl/tdm_highway_port.sv
module tdm_highway_port #(
    parameter int unsigned CNT_W       = 10,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dclk_i,
    input  logic             fsync_i,
    input  logic             rxd_i,
    input  logic             single_rate_i,
    input  logic             standalone_i,
    input  logic             early_sample_i,
    input  logic             open_drain_i,
    input  logic [7:0]       tx_byte_i,
    input  logic             tx_slot_en_i,
    output logic             txd_o,
    output logic             tx_oe_o,
    output logic             tx_take_o,
    output logic [CNT_W-4:0] tx_slot_o,
    output logic [CNT_W-1:0] bit_cnt_o,
    output logic [7:0]       rx_byte_o,
    output logic             rx_valid_o,
    output logic [CNT_W-4:0] rx_slot_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic dclk_rise, dclk_fall, fs_rise, rxd_s;
    logic cell_start, frame_start, rx_sample, framed;
    logic double_rate;
    logic [CNT_W-1:0] cnt_next;

    assign double_rate = ~single_rate_i | standalone_i;

    tdm_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .dclk_i     (dclk_i),
        .fsync_i    (fsync_i),
        .rxd_i      (rxd_i),
        .dclk_rise_o(dclk_rise),
        .dclk_fall_o(dclk_fall),
        .fs_rise_o  (fs_rise),
        .rxd_o      (rxd_s)
    );

    tdm_bit_timer #(.CNT_W(CNT_W)) timer_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .dclk_rise_i  (dclk_rise),
        .dclk_fall_i  (dclk_fall),
        .fs_rise_i    (fs_rise),
        .double_rate_i(double_rate),
        .early_i      (early_sample_i),
        .cell_start_o (cell_start),
        .frame_start_o(frame_start),
        .rx_sample_o  (rx_sample),
        .framed_o     (framed),
        .cnt_o        (bit_cnt_o),
        .cnt_next_o   (cnt_next)
    );

    tdm_tx_ser #(.CNT_W(CNT_W)) tx_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cell_start_i(cell_start),
        .cnt_next_i  (cnt_next),
        .tx_byte_i   (tx_byte_i),
        .tx_en_i     (tx_slot_en_i),
        .od_i        (open_drain_i),
        .txd_o       (txd_o),
        .tx_oe_o     (tx_oe_o),
        .tx_take_o   (tx_take_o),
        .tx_slot_o   (tx_slot_o)
    );

    tdm_rx_deser #(.CNT_W(CNT_W)) rx_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start_i(frame_start),
        .sample_i     (rx_sample),
        .rxd_i        (rxd_s),
        .rx_byte_o    (rx_byte_o),
        .rx_valid_o   (rx_valid_o),
        .rx_slot_o    (rx_slot_o)
    );

    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !framed |-> (!tx_oe_o && txd_o && !rx_valid_o));

    // R3
    take_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take_o |-> (bit_cnt_o[2:0] == 3'd0));

    // R9
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt_o == CNT_MAX) |=> (bit_cnt_o == CNT_MAX || bit_cnt_o == '0));
endmodule

// File: tb/tdm_highway_port_tb_top.sv
`timescale 1ns/1ps
module tdm_highway_port_tb_top;
    localparam int CW   = 6;
    localparam int MAXC = (1 << CW) - 1;
    localparam int H    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dclk = 1'b0, fsync = 1'b0, rxd = 1'b1;
    logic single_rate = 1'b0, standalone = 1'b0, early = 1'b1, od = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic tx_en = 1'b0;
    logic txd, tx_oe, tx_take, rx_valid;
    logic [CW-4:0] tx_slot, rx_slot;
    logic [CW-1:0] bit_cnt;
    logic [7:0] rx_byte;

    always #2.5 clk = ~clk;

    tdm_highway_port #(.CNT_W(CW), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .dclk_i(dclk), .fsync_i(fsync), .rxd_i(rxd),
        .single_rate_i(single_rate), .standalone_i(standalone),
        .early_sample_i(early), .open_drain_i(od),
        .tx_byte_i(tx_byte), .tx_slot_en_i(tx_en),
        .txd_o(txd), .tx_oe_o(tx_oe), .tx_take_o(tx_take), .tx_slot_o(tx_slot),
        .bit_cnt_o(bit_cnt), .rx_byte_o(rx_byte), .rx_valid_o(rx_valid),
        .rx_slot_o(rx_slot)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    bit a_bits [0:127];
    bit b_bits [0:127];
    logic [7:0] tbl [0:15];
    bit en_tbl [0:15];
    bit m_dbl, m_early, m_od, m_sa;
    int m_nbits;
    int rx_seen = 0;
    bit rx_open = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rx(input int s);
        logic [7:0] r = 8'h00;
        for (int k = 0; k < 8; k++) begin
            r = {r[6:0], (m_dbl && !m_early) ? b_bits[8*s+k] : a_bits[8*s+k]};
        end
        return r;
    endfunction

    function automatic bit driven(input int i);
        return (i < MAXC) && (i < m_nbits) && en_tbl[i/8];
    endfunction

    function automatic logic exp_d(input int i);
        if (!driven(i)) return 1'b1;
        return tbl[i/8][7 - (i % 8)];
    endfunction

    function automatic logic exp_oe(input int i);
        if (!driven(i)) return 1'b0;
        return m_od ? !exp_d(i) : 1'b1;
    endfunction

    // receive monitor: R1 (no strobe outside a frame), R6, R7
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (!rx_open) begin
                chk(1'b0, "R1 rx_valid before any frame", 1, 0);
            end else begin
                chk(int'(rx_slot) == rx_seen, "R7 rx slot order", rx_slot, rx_seen);
                chk(rx_byte == exp_rx(int'(rx_slot)), "R6 rx byte", rx_byte, exp_rx(int'(rx_slot)));
                rx_seen++;
            end
        end
    end

    task automatic run_frame(input int nbits, input bit sr, input bit sa, input bit er, input bit o);
        int lim;
        string tag;
        single_rate = sr; standalone = sa; early = er; od = o;
        m_dbl = !sr || sa; m_early = er; m_od = o; m_sa = sa; m_nbits = nbits;
        for (int k = 0; k < 16; k++) begin
            tbl[k] = 8'($urandom);
            en_tbl[k] = ($urandom % 4) != 0;
        end
        for (int k = 0; k < 128; k++) begin
            a_bits[k] = 1'($urandom);
            b_bits[k] = 1'($urandom);
        end
        tx_byte = tbl[0]; tx_en = en_tbl[0];
        rx_seen = 0; rx_open = 1'b1;
        for (int i = 0; i < nbits; i++) begin
            if (i % 8 == 1 && i / 8 + 1 < 16) begin
                tx_byte = tbl[i/8+1]; tx_en = en_tbl[i/8+1];
            end
            dclk = 1'b1; fsync = (i == 0); rxd = a_bits[i];
            repeat (H-1) @(negedge clk);
            tag = (i >= MAXC) ? "R9" : ((sr && !sa) ? "R4" : "R3");
            chk(txd == exp_d(i), {tag, " txd at cell start"}, txd, exp_d(i));
            chk(tx_oe == exp_oe(i), (i >= MAXC) ? "R9 tx_oe" : "R8 tx_oe", tx_oe, exp_oe(i));
            lim = (i < MAXC) ? i : MAXC;
            chk(int'(bit_cnt) == lim, (i >= MAXC) ? "R9 bit count" : "R2 bit count", bit_cnt, lim);
            @(negedge clk); dclk = 1'b0;
            repeat (H) @(negedge clk);
            if (m_dbl) begin
                dclk = 1'b1; fsync = 1'b0; rxd = b_bits[i];
                repeat (H-1) @(negedge clk);
                chk(txd == exp_d(i), sa ? "R5 txd held across double cell" : "R4 txd held across double cell",
                    txd, exp_d(i));
                @(negedge clk); dclk = 1'b0;
                repeat (H) @(negedge clk);
            end
        end
        repeat (H) @(negedge clk);
        lim = ((nbits < MAXC) ? nbits : MAXC) / 8;
        chk(rx_seen == lim, "R7 rx slot count", rx_seen, lim);
    endtask

    initial begin
        void'($urandom(32'h5eed_7a1c));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd == 1'b1, "R1 reset txd", txd, 1);
        chk(tx_oe == 1'b0, "R1 reset tx_oe", tx_oe, 0);
        chk(bit_cnt == '0, "R1 reset bit count", bit_cnt, 0);
        for (int k = 0; k < 6; k++) begin
            dclk = 1'b1; rxd = 1'($urandom);
            repeat (H) @(negedge clk);
            dclk = 1'b0;
            repeat (H) @(negedge clk);
        end
        chk(txd == 1'b1 && tx_oe == 1'b0, "R1 idle with clock running", {txd, tx_oe}, 2'b10);
        chk(bit_cnt == '0, "R1 idle bit count", bit_cnt, 0);
        // directed corner cases
        run_frame(16, 1'b0, 1'b0, 1'b1, 1'b1);
        run_frame(16, 1'b0, 1'b0, 1'b0, 1'b0);
        run_frame(20, 1'b1, 1'b0, 1'b0, 1'b1);
        run_frame(13, 1'b1, 1'b1, 1'b1, 1'b0);
        run_frame(12, 1'b1, 1'b1, 1'b0, 1'b1);
        run_frame(1, 1'b0, 1'b0, 1'b1, 1'b0);
        run_frame(80, 1'b0, 1'b0, 1'b0, 1'b1);
        run_frame(9, 1'b1, 1'b0, 1'b1, 1'b0);
        // random frames
        for (int f = 0; f < 24; f++) begin
            run_frame(1 + int'($urandom % 40), 1'($urandom), (($urandom % 4) == 0),
                      1'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog run did not complete actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule